// File: doc/BRIEF.md
# Bus Clock Source Switch Sequencer

This block decides which clock feeds the bus timing logic of a two-channel parallel ATA controller: a PLL-derived clock or the host-bus clock. Each command issue arrives as a request with a write flag and the number of the issuing channel. The block works out which source that command needs. If the partner channel is idle and the needed source differs from the current one, it runs a five-step isolation and reset sequence across both channels. Only after that does it grant the issue.

The clock multiplexer, the PLL and command execution are outside the block. The block drives the clock-source select code, the per-channel bus tristate enables, the per-channel resets, the per-channel protocol state-machine resets and a one-cycle issue grant. The requester holds `issue_req` until it sees `issue_grant` and drops it in that same cycle.

States: `ST_IDLE` waits for a request. `ST_ISOLATE`, `ST_SWAP`, `ST_SMRESET`, `ST_UNRESET` and `ST_RECONNECT` are the five sequence steps, each held for `STEP_CYCLES` clocks. `ST_GRANT` lasts one cycle.

Transitions:
- IDLE to ISOLATE: a request arrives, the partner is idle and the needed source differs from the current one.
- IDLE to GRANT: a request arrives in any other case.
- Each step to the next step: the step timer expires.
- RECONNECT to GRANT: the step timer expires.
- GRANT to IDLE: always.

Top module: `clksel_seq`

## Requirements
- R1: After reset `src_code` is the host-bus code 8'h23, and `bus_tristate`, `chan_reset`, `sm_reset` and `issue_grant` are all 0.
- R2: A request needs the PLL clock when `issue_write` is 1 or `host66` is 1; otherwise it needs the host-bus clock.
- R3: The partner of channel `issue_chan` is the other channel. If the partner's `chan_idle` bit is 0, no switch happens. The grant asserts in the cycle after the request is accepted, and `src_code` stays unchanged.
- R4: If the needed source equals the current source, no sequence runs, and the grant asserts in the cycle after acceptance.
- R5: A switch runs five steps in this order, each for exactly `STEP_CYCLES` clocks:
  1. Both tristate bits set.
  2. Tristate set, new source code applied and both `chan_reset` bits set.
  3. Tristate and `chan_reset` set, and both `sm_reset` bits set.
  4. Tristate set, with both resets released.
  5. All controls 0.
- R6: `chan_reset` or `sm_reset` is never asserted unless both channels are tristated.
- R7: `issue_grant` stays 0 while a sequence runs. It is high for exactly one cycle: the cycle after the reconnect step ends, or the cycle after acceptance when there is no switch.
- R8: `src_code` is always either the PLL code 8'h21 or the host-bus code 8'h23; the two differ only in bit 1.
- R9: `src_code` changes only on entry to step 2, while both `chan_reset` bits are set.
- R10: Changes to `issue_write`, `host66`, `issue_chan` and `chan_idle` after acceptance and before the grant have no effect on the sequence or on the source it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_req | input | 1 | Command issue request, held until granted |
| issue_write | input | 1 | Request is a write command |
| issue_chan | input | 1 | Channel issuing the command |
| host66 | input | 1 | Host bus runs at 66 MHz |
| chan_idle | input | 2 | Per-channel idle indication |
| src_code | output | 8 | Clock-source select code |
| bus_tristate | output | 2 | Per-channel bus tristate enable |
| chan_reset | output | 2 | Per-channel reset |
| sm_reset | output | 2 | Per-channel state-machine reset |
| issue_grant | output | 1 | One-cycle issue grant |

## Verification
The bench builds the block with `STEP_CYCLES` = 3. That is short enough for many full sequences in both directions, yet long enough that a step cut short or stretched by one clock shows up as a wrong control pattern in a specific cycle. Every cycle of every transaction is compared against a phase model. The bench mixes the write flag, the 66 MHz flag, the issuing channel and the idle bits, and it changes those inputs in the middle of a sequence. It also includes directed cases: a busy partner on each channel, a repeat request for the same source, and switches in both directions.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int N_CHAN = 2;
    localparam int CODE_W = 8;

    // Select codes: PLL and host-bus clock differ only in bit 1
    localparam logic [CODE_W-1:0] SRC_PLL_CODE  = 8'h21;
    localparam logic [CODE_W-1:0] SRC_HOST_CODE = 8'h23;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISOLATE,
        ST_SWAP,
        ST_SMRESET,
        ST_UNRESET,
        ST_RECONNECT,
        ST_GRANT
    } seq_state_t;

    typedef struct packed {
        logic tristate;
        logic chan_rst;
        logic sm_rst;
        logic grant;
    } seq_ctl_t;

endpackage

// File: rtl/clksel_policy.sv
module clksel_policy
    import clksel_pkg::*;
(
    input  logic              write_i,
    input  logic              host66_i,
    input  logic              chan_i,
    input  logic [N_CHAN-1:0] idle_i,
    input  logic              cur_pll_i,
    output logic              need_pll_o,
    output logic              do_switch_o
);

    logic partner_idle;

    always_comb begin
        // writes and a fast host bus both demand the PLL clock
        need_pll_o   = write_i | host66_i;
        partner_idle = idle_i[chan_i ^ 1'b1];
        do_switch_o  = partner_idle && (need_pll_o != cur_pll_i);
    end

endmodule

// File: rtl/clksel_step_timer.sv
module clksel_step_timer #(
    parameter int STEP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic last_o
);

    localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = (cnt_q == CNT_LAST);

endmodule

// File: rtl/clksel_fsm.sv
module clksel_fsm
    import clksel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_i,
    input  logic     need_pll_i,
    input  logic     do_switch_i,
    input  logic     step_last_i,
    output logic     step_clear_o,
    output logic     cur_pll_o,
    output seq_ctl_t ctl_o
);

    seq_state_t state_q, state_d;
    logic       tgt_pll_q;
    logic       cur_pll_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // target latched at acceptance, applied on entry to the swap step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_pll_q <= 1'b0;
            cur_pll_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_i && do_switch_i) begin
                tgt_pll_q <= need_pll_i;
            end
            if (state_q == ST_ISOLATE && step_last_i) begin
                cur_pll_q <= tgt_pll_q;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    state_d = do_switch_i ? ST_ISOLATE : ST_GRANT;
                end
            end
            ST_ISOLATE:   if (step_last_i) state_d = ST_SWAP;
            ST_SWAP:      if (step_last_i) state_d = ST_SMRESET;
            ST_SMRESET:   if (step_last_i) state_d = ST_UNRESET;
            ST_UNRESET:   if (step_last_i) state_d = ST_RECONNECT;
            ST_RECONNECT: if (step_last_i) state_d = ST_GRANT;
            ST_GRANT:     state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    assign step_clear_o = (state_d != state_q);
    assign cur_pll_o    = cur_pll_q;

    // outputs
    always_comb begin
        ctl_o = '0;
        unique case (state_q)
            ST_IDLE:      ctl_o = '0;
            ST_ISOLATE:   ctl_o.tristate = 1'b1;
            ST_SWAP: begin
                ctl_o.tristate = 1'b1;
                ctl_o.chan_rst = 1'b1;
            end
            ST_SMRESET: begin
                ctl_o.tristate = 1'b1;
                ctl_o.chan_rst = 1'b1;
                ctl_o.sm_rst   = 1'b1;
            end
            ST_UNRESET:   ctl_o.tristate = 1'b1;
            ST_RECONNECT: ctl_o = '0;
            ST_GRANT:     ctl_o.grant = 1'b1;
            default:      ctl_o = '0;
        endcase
    end

endmodule

// File: rtl/clksel_seq.sv
module clksel_seq
    import clksel_pkg::*;
#(
    parameter int STEP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_req,
    input  logic              issue_write,
    input  logic              issue_chan,
    input  logic              host66,
    input  logic [N_CHAN-1:0] chan_idle,
    output logic [CODE_W-1:0] src_code,
    output logic [N_CHAN-1:0] bus_tristate,
    output logic [N_CHAN-1:0] chan_reset,
    output logic [N_CHAN-1:0] sm_reset,
    output logic              issue_grant
);

    logic     need_pll;
    logic     do_switch;
    logic     cur_pll;
    logic     step_last;
    logic     step_clear;
    seq_ctl_t ctl;

    clksel_policy u_policy (
        .write_i     (issue_write),
        .host66_i    (host66),
        .chan_i      (issue_chan),
        .idle_i      (chan_idle),
        .cur_pll_i   (cur_pll),
        .need_pll_o  (need_pll),
        .do_switch_o (do_switch)
    );

    clksel_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (step_clear),
        .last_o  (step_last)
    );

    clksel_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (issue_req),
        .need_pll_i   (need_pll),
        .do_switch_i  (do_switch),
        .step_last_i  (step_last),
        .step_clear_o (step_clear),
        .cur_pll_o    (cur_pll),
        .ctl_o        (ctl)
    );

    // every channel sees the same step controls
    generate
        for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
            assign bus_tristate[ch] = ctl.tristate;
            assign chan_reset[ch]   = ctl.chan_rst;
            assign sm_reset[ch]     = ctl.sm_rst;
        end
    endgenerate

    assign src_code    = cur_pll ? SRC_PLL_CODE : SRC_HOST_CODE;
    assign issue_grant = ctl.grant;

endmodule

// File: rtl/clksel_seq_chk.sv
module clksel_seq_chk
    import clksel_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] src_code,
    input logic [N_CHAN-1:0] bus_tristate,
    input logic [N_CHAN-1:0] chan_reset,
    input logic [N_CHAN-1:0] sm_reset,
    input logic              issue_grant
);

    a_r8_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (src_code == SRC_PLL_CODE) || (src_code == SRC_HOST_CODE));

    a_r6_reset_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        ((|chan_reset) || (|sm_reset)) |-> (bus_tristate == '1));

    a_r5_smrst_in_chrst: assert property (@(posedge clk) disable iff (!rst_n)
        (|sm_reset) |-> (chan_reset == '1));

    a_r7_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant |=> !issue_grant);

    a_r7_grant_connected: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant |-> (bus_tristate == '0 && chan_reset == '0 && sm_reset == '0));

    a_r9_src_under_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_code) |-> (chan_reset == '1 && sm_reset == '0));

    a_r5_release_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chan_reset[0]) |-> (bus_tristate == '1));

endmodule

bind clksel_seq clksel_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_code     (src_code),
    .bus_tristate (bus_tristate),
    .chan_reset   (chan_reset),
    .sm_reset     (sm_reset),
    .issue_grant  (issue_grant)
);

// File: tb/sim_clksel_seq.sv
`timescale 1ns/1ps
module sim_clksel_seq;

    localparam int S = 3;
    localparam logic [7:0] PLL_C  = 8'h21;
    localparam logic [7:0] HOST_C = 8'h23;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_req = 1'b0;
    logic       issue_write = 1'b0;
    logic       issue_chan = 1'b0;
    logic       host66 = 1'b0;
    logic [1:0] chan_idle = 2'b11;
    logic [7:0] src_code;
    logic [1:0] bus_tristate, chan_reset, sm_reset;
    logic       issue_grant;

    int n_chk = 0;
    int n_bad = 0;
    logic model_pll = 1'b0;
    int unsigned seed = 32'd1234;

    always #4 clk = ~clk;

    clksel_seq #(.STEP_CYCLES(S)) u0 (
        .clk(clk), .rst_n(rst_n), .issue_req(issue_req), .issue_write(issue_write),
        .issue_chan(issue_chan), .host66(host66), .chan_idle(chan_idle),
        .src_code(src_code), .bus_tristate(bus_tristate), .chan_reset(chan_reset),
        .sm_reset(sm_reset), .issue_grant(issue_grant)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected {tristate, chan_reset, sm_reset, grant} for cycle j of a transaction
    function automatic logic [3:0] exp_ctl(input bit sw, input int j);
        int ph;
        if (!sw) return (j == 1) ? 4'b0001 : 4'b0000;
        if (j == 5*S + 1) return 4'b0001;
        ph = (j - 1) / S;
        case (ph)
            0: return 4'b1000;
            1: return 4'b1100;
            2: return 4'b1110;
            3: return 4'b1000;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic check_outputs(input string tag, input logic [3:0] e, input logic [7:0] esrc);
        chk({tag, " tristate"}, {30'd0, bus_tristate}, {30'd0, {2{e[3]}}});
        chk({tag, " chan_reset"}, {30'd0, chan_reset}, {30'd0, {2{e[2]}}});
        chk({tag, " sm_reset"}, {30'd0, sm_reset}, {30'd0, {2{e[1]}}});
        chk({tag, " grant"}, {31'd0, issue_grant}, {31'd0, e[0]});
        chk({tag, " src"}, {24'd0, src_code}, {24'd0, esrc});
    endtask

    // one issue: drive at negedge, check every cycle until grant
    task automatic issue(input logic wr, input logic h66, input logic ch,
                         input logic [1:0] idle, input bit scramble);
        logic need;
        bit   sw;
        logic [7:0] old_src, new_src, esrc;
        int   last;
        need = wr | h66;
        sw = idle[ch ^ 1'b1] && (need != model_pll);
        old_src = model_pll ? PLL_C : HOST_C;
        new_src = need ? PLL_C : HOST_C;
        last = sw ? 5*S + 1 : 1;
        issue_req = 1'b1; issue_write = wr; host66 = h66;
        issue_chan = ch; chan_idle = idle;
        for (int j = 1; j <= last; j++) begin
            @(posedge clk);
            @(negedge clk);
            esrc = (sw && j >= S + 1) ? new_src : old_src;
            if (!sw) check_outputs(idle[ch ^ 1'b1] ? "R4" : "R3", exp_ctl(sw, j), esrc);
            else if (j > 5*S) check_outputs("R7", exp_ctl(sw, j), esrc);
            else check_outputs("R5", exp_ctl(sw, j), esrc);
            if (j < last && scramble) begin
                // R10: inputs move mid-sequence
                issue_write = $urandom % 2; host66 = $urandom % 2;
                issue_chan = $urandom % 2; chan_idle = $urandom % 4;
            end
        end
        issue_req = 1'b0;
        if (sw) model_pll = need;
        @(posedge clk);
        @(negedge clk);
        check_outputs("R7 idle", 4'b0000, model_pll ? PLL_C : HOST_C);
    endtask

    initial begin
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check_outputs("R1 in reset", 4'b0000, HOST_C);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1 after reset", 4'b0000, HOST_C);

        // directed corners
        issue(1'b0, 1'b0, 1'b0, 2'b11, 0);   // R4 read on host clock: no switch
        issue(1'b1, 1'b0, 1'b0, 2'b01, 0);   // R3 partner ch1 busy: no switch
        issue(1'b1, 1'b0, 1'b1, 2'b10, 0);   // R3 partner ch0 busy: no switch
        issue(1'b1, 1'b0, 1'b0, 2'b11, 0);   // R2 write -> PLL, R5 sequence
        issue(1'b1, 1'b1, 1'b1, 2'b11, 0);   // R4 already PLL
        issue(1'b0, 1'b0, 1'b1, 2'b11, 1);   // R2 read -> host, R10 scrambled
        issue(1'b0, 1'b1, 1'b0, 2'b11, 1);   // R2 host66 read -> PLL, R8 code
        issue(1'b0, 1'b0, 1'b0, 2'b11, 0);   // back to host

        // constrained random
        for (int k = 0; k < 300; k++) begin
            issue($urandom % 2, ($urandom % 4) == 0, $urandom % 2,
                  (($urandom % 4) == 0) ? 2'($urandom % 4) : 2'b11, ($urandom % 2) == 1);
            if (($urandom % 3) == 0) begin
                @(negedge clk);
                check_outputs("R7 gap", 4'b0000, model_pll ? PLL_C : HOST_C);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule